// File: doc/BRIEF.md
# TDM Audio Transmit Slot Controller

This block is the transmit half of a serial audio port. Software places parallel sample words in two one-deep holding registers, one per channel. At the start of each active time slot the controller moves a word into a shift register and sends it on a single data line, most significant bit first, one bit per bit-clock tick. The bit clock is generated elsewhere and reaches the block as a one-cycle tick.

There are two framing modes. In network (TDM) mode a frame has a programmable number of slots, and a per-slot mask can silence any slot; a silenced slot releases the data line. In normal mode a frame has one slot, or two slots when two-channel operation is on, and the mask has no effect. When a slot needs a word and its holding register is empty, the controller flags an underrun for that channel and sends the last transmitted word again. A frame-sync status flag marks the first slot of the frame. The underrun flags are cleared by writing one, and a gated interrupt combines the status flags.

Top module: `aud_tx_slot_ctrl`

## Requirements
- R1: After reset, sdo_oe, sdo, fs_flag, und_flag and irq are 0 and hold_empty is all ones.
- R2: An active slot lasts W bit ticks and sends the low W bits of the loaded word, MSB first. The word_len code sets W: 0 gives 8, 1 gives 16, 2 gives 24, 3 gives 32. sdo_oe is 1 for the whole slot.
- R3: A network-mode frame has slot_last+1 slots. A normal-mode frame has 1 slot, or 2 when dual_ch is 1. With dual_ch set, odd slots take channel 1 and even slots take channel 0. Otherwise every slot takes channel 0.
- R4: In network mode, slot i is masked when slot_mask bit i is 1. A masked slot holds sdo_oe and sdo at 0, loads nothing and flags no underrun, and its holding register keeps its word. Normal mode ignores slot_mask.
- R5: When an active channel-0 slot starts with holding register 0 empty, und_flag[0] is set and the slot sends the previously transmitted word again.
- R6: Channel 1 underrun (und_flag[1]) is flagged under the same rule as R5, and only while dual_ch is 1.
- R7: fs_flag is 1 while slot 0 of a frame is being sent and 0 in every other slot and while idle. In single-channel normal mode, fs_flag therefore stays high.
- R8: A word written to a channel's holding register during a slot is sent in the next active slot of that channel. hold_empty[c] is 0 from the write until that load.
- R9: A cycle with st_clr_wr high clears und_flag[c] for each c where st_clr_bits[c] is 1 (bit 0 is channel 0, bit 1 is channel 1). A 0 bit leaves its flag unchanged.
- R10: irq equals irq_en AND (any und_flag[c] with und_ie[c] set, OR fs_flag with fs_ie set).
- R11: One cycle after tx_en falls, sdo_oe and fs_flag are 0. The next enable starts again at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | One-cycle pulse per serial bit period |
| tx_en | input | 1 | Transmitter enable |
| net_mode | input | 1 | 1 selects network (TDM) framing, 0 selects normal framing |
| dual_ch | input | 1 | Two-channel operation |
| word_len | input | 2 | Word length code: 8, 16, 24 or 32 bits |
| slot_last | input | 5 | Number of slots per network frame, minus one |
| slot_mask | input | 32 | Per-slot mask in network mode, 1 means silent |
| hold_wr | input | 2 | Write strobe for each channel's holding register |
| hold_wdata | input | 32 | Holding register write data, word in the low bits |
| st_clr_wr | input | 1 | Write-one-to-clear strobe for the underrun flags |
| st_clr_bits | input | 2 | Underrun flags to clear |
| irq_en | input | 1 | Global transmit interrupt enable |
| und_ie | input | 2 | Per-channel underrun interrupt enables |
| fs_ie | input | 1 | Frame-sync interrupt enable |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data line drive enable |
| fs_flag | output | 1 | Frame-sync status |
| und_flag | output | 2 | Underrun status per channel |
| hold_empty | output | 2 | Holding register empty per channel |
| irq | output | 1 | Transmit interrupt |

## Verification
A wrong bit or slot counter appears at the next slot boundary. The word is cut at the wrong length, or fs_flag comes up in a slot other than the first, and the bench sees it within one slot time. A wrong holding-register or last-word state appears when that channel's word is next loaded: the bench sees a repeated or stale word on sdo, a spurious or missing underrun flag, or a wrong hold_empty at the end of that slot. A bad mask decode shows as sdo_oe driven in a silent slot, or released in a live one, from the first bit of that slot.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;
  localparam int NCH = 2;

  // word length code to bit count: 0->8, 1->16, 2->24, 3->32
  function automatic int wlen_bits(input logic [1:0] code);
    return (int'(code) + 1) * 8;
  endfunction
endpackage

// File: rtl/aud_slot_timer.sv
`timescale 1ns/1ps
module aud_slot_timer #(
  parameter  int NSLOT = 32,
  parameter  int DW    = 32,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int BW    = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          net_mode,
  input  logic          dual_ch,
  input  logic [SW-1:0] slot_last,
  input  logic [BW-1:0] wbits,
  output logic          run,
  output logic [SW-1:0] slot_idx,
  output logic          load,
  output logic [SW-1:0] load_slot
);
  logic          run_q, run_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [SW-1:0] slot_q, slot_d, last_eff, nxt;
  logic          bnd;

  always_comb begin
    last_eff = net_mode ? slot_last : SW'(dual_ch);
    bnd      = tick && tx_en && (!run_q || (bit_q == wbits - BW'(1)));
    nxt      = (!run_q || (slot_q >= last_eff)) ? '0 : slot_q + SW'(1);
    run_d    = run_q;
    bit_d    = bit_q;
    slot_d   = slot_q;
    if (!tx_en) begin
      run_d  = 1'b0;
      bit_d  = '0;
      slot_d = '0;
    end else if (bnd) begin
      run_d  = 1'b1;
      bit_d  = '0;
      slot_d = nxt;
    end else if (tick && run_q) begin
      bit_d  = bit_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      run_q  <= run_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
    end
  end

  assign run       = run_q;
  assign slot_idx  = slot_q;
  assign load      = bnd;
  assign load_slot = nxt;
endmodule

// File: rtl/aud_hold_bank.sv
`timescale 1ns/1ps
module aud_hold_bank #(
  parameter int DW  = 32,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          wr,
  input  logic [DW-1:0]           wdata,
  input  logic [NCH-1:0]          take,
  output logic [NCH-1:0]          full,
  output logic [NCH-1:0][DW-1:0]  data
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          full_q, full_d;
    logic [DW-1:0] data_q;

    always_comb full_d = wr[c] | (full_q & ~take[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else begin
        full_q <= full_d;
        if (wr[c]) data_q <= wdata;
      end
    end

    assign full[c] = full_q;
    assign data[c] = data_q;
  end
endmodule

// File: rtl/aud_tx_shifter.sv
`timescale 1ns/1ps
module aud_tx_shifter #(
  parameter  int DW = 32,
  localparam int BW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          tick,
  input  logic          run,
  input  logic          load,
  input  logic          load_act,
  input  logic          use_new,
  input  logic [DW-1:0] new_word,
  input  logic [BW-1:0] wbits,
  output logic          sdo,
  output logic          oe
);
  logic [DW-1:0] sreg_q, sreg_d, last_q, last_d, word;
  logic          oe_q, oe_d;

  always_comb begin
    word   = use_new ? new_word : last_q;
    sreg_d = sreg_q;
    last_d = last_q;
    oe_d   = oe_q;
    if (!tx_en) begin
      oe_d = 1'b0;
    end else if (load) begin
      oe_d = load_act;
      if (load_act) begin
        sreg_d = word << (DW - int'(wbits));
        last_d = word;
      end
    end else if (tick && run) begin
      sreg_d = sreg_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      last_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      last_q <= last_d;
      oe_q   <= oe_d;
    end
  end

  assign oe  = oe_q;
  assign sdo = oe_q & sreg_q[DW-1];
endmodule

// File: rtl/aud_tx_status.sv
`timescale 1ns/1ps
module aud_tx_status #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] und_set,
  input  logic           clr_wr,
  input  logic [NCH-1:0] clr_bits,
  input  logic           fs_flag,
  input  logic           irq_en,
  input  logic [NCH-1:0] und_ie,
  input  logic           fs_ie,
  output logic [NCH-1:0] und_flag,
  output logic           irq
);
  logic [NCH-1:0] und_q, und_d;

  always_comb und_d = (und_q & ~(clr_wr ? clr_bits : '0)) | und_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) und_q <= '0;
    else        und_q <= und_d;
  end

  assign und_flag = und_q;
  assign irq      = irq_en & ((|(und_q & und_ie)) | (fs_flag & fs_ie));
endmodule

// File: rtl/aud_tx_slot_ctrl.sv
`timescale 1ns/1ps
module aud_tx_slot_ctrl
  import aud_tx_pkg::*;
#(
  parameter  int DW    = 32,
  parameter  int NSLOT = 32,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int BW    = $clog2(DW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_tick,
  input  logic             tx_en,
  input  logic             net_mode,
  input  logic             dual_ch,
  input  logic [1:0]       word_len,
  input  logic [SW-1:0]    slot_last,
  input  logic [NSLOT-1:0] slot_mask,
  input  logic [NCH-1:0]   hold_wr,
  input  logic [DW-1:0]    hold_wdata,
  input  logic             st_clr_wr,
  input  logic [NCH-1:0]   st_clr_bits,
  input  logic             irq_en,
  input  logic [NCH-1:0]   und_ie,
  input  logic             fs_ie,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             fs_flag,
  output logic [NCH-1:0]   und_flag,
  output logic [NCH-1:0]   hold_empty,
  output logic             irq
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [BW-1:0]         wbits;
  logic                  run, load, load_act, load_ch, use_new;
  logic [SW-1:0]         slot_idx, load_slot;
  logic [NCH-1:0]        hold_full, take, und_set;
  logic [NCH-1:0][DW-1:0] hold_data;

  assign wbits = BW'(wlen_bits(word_len));

  aud_slot_timer #(.NSLOT(NSLOT), .DW(DW)) u_timer (
    .clk(clk), .rst_n(rst_i), .tick(bclk_tick), .tx_en(tx_en),
    .net_mode(net_mode), .dual_ch(dual_ch), .slot_last(slot_last),
    .wbits(wbits), .run(run), .slot_idx(slot_idx), .load(load),
    .load_slot(load_slot)
  );

  // slot activity and channel choice at the boundary
  assign load_act = load && !(net_mode && slot_mask[load_slot]);
  assign load_ch  = dual_ch & load_slot[0];

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    logic hit;
    assign hit        = load_act && (load_ch == 1'(c));
    assign take[c]    = hit & hold_full[c];
    assign und_set[c] = hit & ~hold_full[c] & ((c == 0) || dual_ch);
  end

  assign use_new = hold_full[load_ch];

  aud_hold_bank #(.DW(DW), .NCH(NCH)) u_hold (
    .clk(clk), .rst_n(rst_i), .wr(hold_wr), .wdata(hold_wdata),
    .take(take), .full(hold_full), .data(hold_data)
  );

  aud_tx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_i), .tx_en(tx_en), .tick(bclk_tick), .run(run),
    .load(load), .load_act(load_act), .use_new(use_new),
    .new_word(hold_data[load_ch]), .wbits(wbits), .sdo(sdo), .oe(sdo_oe)
  );

  assign fs_flag = run && (slot_idx == '0);

  aud_tx_status #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_i), .und_set(und_set), .clr_wr(st_clr_wr),
    .clr_bits(st_clr_bits), .fs_flag(fs_flag), .irq_en(irq_en),
    .und_ie(und_ie), .fs_ie(fs_ie), .und_flag(und_flag), .irq(irq)
  );

  assign hold_empty = ~hold_full;
endmodule

// File: rtl/aud_tx_slot_ctrl_chk.sv
`timescale 1ns/1ps
module aud_tx_slot_ctrl_chk #(
  parameter  int NSLOT = 32,
  parameter  int NCH   = 2,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             net_mode,
  input logic             dual_ch,
  input logic [NSLOT-1:0] slot_mask,
  input logic             load,
  input logic [SW-1:0]    load_slot,
  input logic             load_act,
  input logic             load_ch,
  input logic [NCH-1:0]   hold_full,
  input logic             sdo_oe,
  input logic             fs_flag,
  input logic [NCH-1:0]   und_flag,
  input logic             irq_en,
  input logic             irq
);
  // R4: a slot that starts masked in network mode never drives the line
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load && net_mode && slot_mask[load_slot]) |-> !sdo_oe);

  // R5: channel 0 underrun rises only after an empty channel-0 load
  a_r5_und0_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(und_flag[0]) |-> $past(load_act && !load_ch && !hold_full[0]));

  // R6: channel 1 underrun needs two-channel operation
  a_r6_und1_dual: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(und_flag[1]) |-> $past(dual_ch));

  // R7: frame sync only begins at a slot boundary
  a_r7_fs_at_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_flag) |-> $past(load));

  // R10: no interrupt without the global enable
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R11: disabling releases the line and drops frame sync
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!sdo_oe && !fs_flag));
endmodule

bind aud_tx_slot_ctrl aud_tx_slot_ctrl_chk #(.NSLOT(NSLOT), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .net_mode(net_mode),
  .dual_ch(dual_ch), .slot_mask(slot_mask), .load(load),
  .load_slot(load_slot), .load_act(load_act), .load_ch(load_ch),
  .hold_full(hold_full), .sdo_oe(sdo_oe), .fs_flag(fs_flag),
  .und_flag(und_flag), .irq_en(irq_en), .irq(irq)
);

// File: tb/aud_tx_slot_ctrl_bench.sv
`timescale 1ns/1ps
module aud_tx_slot_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n, bclk_tick, tx_en, net_mode, dual_ch;
  logic [1:0]  word_len;
  logic [4:0]  slot_last;
  logic [31:0] slot_mask;
  logic [1:0]  hold_wr;
  logic [31:0] hold_wdata;
  logic        st_clr_wr;
  logic [1:0]  st_clr_bits;
  logic        irq_en;
  logic [1:0]  und_ie;
  logic        fs_ie;
  logic        sdo, sdo_oe, fs_flag, irq;
  logic [1:0]  und_flag, hold_empty;

  always #10 clk = ~clk;  // 50 MHz

  aud_tx_slot_ctrl u_aud_tx_slot_ctrl (
    .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .tx_en(tx_en),
    .net_mode(net_mode), .dual_ch(dual_ch), .word_len(word_len),
    .slot_last(slot_last), .slot_mask(slot_mask), .hold_wr(hold_wr),
    .hold_wdata(hold_wdata), .st_clr_wr(st_clr_wr), .st_clr_bits(st_clr_bits),
    .irq_en(irq_en), .und_ie(und_ie), .fs_ie(fs_ie), .sdo(sdo),
    .sdo_oe(sdo_oe), .fs_flag(fs_flag), .und_flag(und_flag),
    .hold_empty(hold_empty), .irq(irq)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int cyc   = 0;

  // reference model state
  logic [31:0] m_hold [2];
  bit   [1:0]  m_full;
  logic [31:0] m_last;
  bit   [1:0]  m_und;
  logic [31:0] seed = 32'h1357_9BDF;

  typedef struct {
    bit          act;
    bit          und;
    logic [31:0] w;
  } exp_t;
  exp_t sb_q[$];

  function automatic logic [31:0] gen_word();
    seed = seed * 32'h0019_660D + 32'h3C6E_F35F;
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // driver side: one holding write, model updated in step
  task automatic prewrite(input int c);
    logic [31:0] d;
    d = gen_word();
    hold_wr[c] = 1'b1;
    hold_wdata = d;
    m_hold[c]  = d;
    m_full[c]  = 1'b1;
    @(negedge clk);
    hold_wr = 2'b00;
  endtask

  task automatic run_frames(input bit net, input bit dual, input logic [1:0] wl,
                            input int sl, input logic [31:0] mask,
                            input int nslots, input logic [63:0] skip);
    int          wb, nsl;
    logic [31:0] wmask;
    wb    = (int'(wl) + 1) * 8;
    nsl   = net ? sl + 1 : (dual ? 2 : 1);
    wmask = 32'((64'd1 << wb) - 64'd1);
    net_mode  = net;
    dual_ch   = dual;
    word_len  = wl;
    slot_last = 5'(sl);
    slot_mask = mask;
    tx_en     = 1'b1;
    for (int s = 0; s < nslots; s++) begin
      int          fi, ch;
      bit          act, und;
      logic [31:0] word, got;
      bit          oe_all, oe_any;
      exp_t        e;
      fi  = s % nsl;
      ch  = dual ? (fi % 2) : 0;
      act = !(net && mask[fi]);
      und = 1'b0;
      word = 32'h0;
      if (act) begin
        if (m_full[ch]) begin
          word = m_hold[ch];
          m_full[ch] = 1'b0;
        end else begin
          word = m_last;
          m_und[ch] = 1'b1;
          und = 1'b1;
        end
        m_last = word;
      end
      e.act = act; e.und = und; e.w = word & wmask;
      sb_q.push_back(e);
      got = 32'h0; oe_all = 1'b1; oe_any = 1'b0;
      for (int k = 0; k < wb; k++) begin
        @(negedge clk);
        got    = {got[30:0], sdo};
        oe_all = oe_all & sdo_oe;
        oe_any = oe_any | sdo_oe;
        if (k == 0) begin
          check(fs_flag == (fi == 0), "R7", "fs_flag in slot",
                32'(fs_flag), 32'(fi == 0));
          check(irq == (irq_en && (((m_und & und_ie) != 2'b00) || (fi == 0 && fs_ie))),
                "R10", "irq in slot", 32'(irq),
                32'(irq_en && (((m_und & und_ie) != 2'b00) || (fi == 0 && fs_ie))));
          if (act && !skip[s]) prewrite_inline(ch);
        end
        if (k == 1) hold_wr = 2'b00;
      end
      if (s == nslots - 1) tx_en = 1'b0;
      // monitor side: pop the expectation for this slot and compare
      e = sb_q.pop_front();
      if (e.act)
        check(oe_all && (got == e.w), e.und ? "R5" : "R2", "slot word",
              oe_all ? got : 32'hDEAD_0E00, e.w);
      else
        check(!oe_any && got == 32'h0, "R4", "masked slot line",
              {31'h0, oe_any}, 32'h0);
      check(hold_empty == ~m_full, act ? "R8" : "R4", "hold_empty after slot",
            32'(hold_empty), 32'(~m_full));
    end
    @(negedge clk);
    check(!sdo_oe && !fs_flag, "R11", "idle after disable",
          {30'h0, sdo_oe, fs_flag}, 32'h0);
  endtask

  // write at the current negedge; deasserted by the caller one bit later
  task automatic prewrite_inline(input int c);
    logic [31:0] d;
    d = gen_word();
    hold_wr[c] = 1'b1;
    hold_wdata = d;
    m_hold[c]  = d;
    m_full[c]  = 1'b1;
  endtask

  task automatic clear_flags(input logic [1:0] bits);
    st_clr_wr   = 1'b1;
    st_clr_bits = bits;
    m_und       = m_und & ~bits;
    @(negedge clk);
    st_clr_wr   = 1'b0;
    st_clr_bits = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; bclk_tick = 1'b1; tx_en = 1'b0; net_mode = 1'b0;
    dual_ch = 1'b0; word_len = 2'd0; slot_last = 5'd0; slot_mask = 32'h0;
    hold_wr = 2'b00; hold_wdata = 32'h0; st_clr_wr = 1'b0; st_clr_bits = 2'b00;
    irq_en = 1'b1; und_ie = 2'b01; fs_ie = 1'b1;
    m_hold[0] = 32'h0; m_hold[1] = 32'h0; m_full = 2'b00;
    m_last = 32'h0; m_und = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!sdo_oe && !sdo && !fs_flag, "R1", "line and fs after reset",
          {29'h0, sdo_oe, sdo, fs_flag}, 32'h0);
    check(und_flag == 2'b00 && !irq, "R1", "flags and irq after reset",
          {29'h0, und_flag, irq}, 32'h0);
    check(hold_empty == 2'b11, "R1", "hold_empty after reset",
          32'(hold_empty), 32'h3);

    // R2 R3 R8: network, single channel, 16-bit words, 4-slot frames
    prewrite(0);
    run_frames(1'b1, 1'b0, 2'd1, 3, 32'h0, 8, 64'h0);
    check(und_flag == m_und, "R5", "no underrun with steady writes",
          32'(und_flag), 32'(m_und));

    // R5 R4: 8-bit words, slot 2 masked, write skipped in slot 1
    run_frames(1'b1, 1'b0, 2'd0, 3, 32'h0000_0004, 4, 64'h2);
    check(und_flag == 2'b01, "R5", "underrun ch0 flagged",
          32'(und_flag), 32'h1);

    // R9 write-one-to-clear
    clear_flags(2'b10);
    check(und_flag == 2'b01, "R9", "zero bit keeps ch0 flag",
          32'(und_flag), 32'h1);
    clear_flags(2'b01);
    check(und_flag == 2'b00, "R9", "one bit clears ch0 flag",
          32'(und_flag), 32'h0);

    // R4 masked slot leaves a full holding register alone
    run_frames(1'b1, 1'b0, 2'd0, 1, 32'h0000_0002, 4, 64'h0);

    // R3 R6 normal dual, 24-bit, mask ignored, ch1 writes skipped
    prewrite(0);
    prewrite(1);
    run_frames(1'b0, 1'b1, 2'd2, 0, 32'hFFFF_FFFF, 6, 64'h28);
    check(und_flag == 2'b10, "R6", "underrun ch1 in dual mode",
          32'(und_flag), 32'h2);
    check(hold_empty[1] == 1'b1, "R6", "ch1 left empty",
          32'(hold_empty[1]), 32'h1);
    clear_flags(2'b10);
    check(und_flag == 2'b00, "R9", "one bit clears ch1 flag",
          32'(und_flag), 32'h0);

    // R6 R7 normal single, 32-bit: ch1 empty but never flagged, fs stays high
    run_frames(1'b0, 1'b0, 2'd3, 0, 32'h0, 4, 64'h2);
    check(und_flag == 2'b01, "R6", "only ch0 flagged in single mode",
          32'(und_flag), 32'h1);

    // R10 interrupt gating with ch0 flag set and idle
    irq_en = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R10", "global enable off", 32'(irq), 32'h0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10", "ch0 flag with enable", 32'(irq), 32'h1);
    und_ie = 2'b10;
    @(negedge clk);
    check(irq == 1'b0, "R10", "ch0 flag without its enable", 32'(irq), 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule